// File: doc/BRIEF.md
# Serial Peripheral Master with Byte-Order Swap and Timed Gaps

The block is the shift engine of a serial peripheral (SPI) master. Software writes one or two transmit words and a control word, then sets a go bit. The engine drops chip select, toggles the serial clock once for every pulse of an enable-tick input, and shifts each word out most significant bit first while it captures the returned bits. A word can be 8, 16, 24 or 32 bits long. When the last transaction ends, the received words appear in two receive registers, a done flag rises and the interrupt output follows that flag if interrupts are enabled.

Two options change the shape of a transfer. First, the byte order of a word can be reversed before it is shifted out, and the same reversal is applied to the captured word before it is stored. Second, an idle gap of (suspend field + 2) serial clock cycles can be placed between the bytes of a 32-bit word, or between the two transactions of a burst. Each gap is measured from the trailing clock edge of one bit to the leading edge of the next, so the polarity setting decides which edge direction bounds it. A two-line mode shifts two data lines in parallel for a single transaction.

Top module: `spi_reorder_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, irq is 0, and the control word (address 0) and receive word 0 (address 3) both read as 0.
- R2: The word-length field, control bits [4:3], selects 32 bits (code 0), 8 (code 1), 16 (code 2) or 24 (code 3). Each transaction has that many leading sclk edges, and the low bits of the transmit word go out most significant bit first.
- R3: Control bit 1 sets the sclk idle level. mosi changes on trailing edges, miso is sampled on leading edges, and sclk changes only in a cycle that follows a sclk_tick pulse.
- R4: The 2-bit order/gap field, control bits [6:5], selects: 00 neither option, 01 byte reversal with byte gaps, 10 byte reversal only, 11 byte gaps only.
- R5: With byte reversal on, the bytes of the transmit word's low L bits are sent in reverse order, so the least significant byte goes first. The captured L-bit word is reversed in the same way before it is stored.
- R6: With byte gaps on (legal with 32-bit words only), each byte boundary inside a word has a gap of (S+2) sclk cycles, where S is the suspend field in control bits [11:8]. The gap runs from the trailing edge of the last bit of one byte to the leading edge of the first bit of the next.
- R7: Control bit 7 requests a burst of two transactions. The first sends transmit word 0 (address 1) and stores into receive word 0 (address 3). The second sends transmit word 1 (address 2) and stores into receive word 1 (address 4). A gap of (S+2) sclk cycles separates them, and cs_n stays low across both.
- R8: Without a burst, a transfer has one transaction and no gap, whatever the value of the suspend field. Receive word 1 keeps its previous value.
- R9: Control bit 12 selects two-line mode. mosi0 carries transmit word 0 and mosi1 carries transmit word 1 in the same clock cycles. miso0 is stored into receive word 0 and miso1 into receive word 1, in one transaction.
- R10: The done flag, control bit 16, is set when a transfer ends. Writing 1 to that bit clears it, and writing 0 leaves it set. irq is high exactly when the flag and control bit 13 (interrupt enable) are both 1.
- R11: Writing control bit 0 as 1 starts a transfer. Bit 0 then reads as 1 until the transfer ends, and cs_n is 1 whenever no transfer is in progress.
- R12: All register writes are ignored while a transfer is in progress. Both the transfer and the read-back values are unaffected by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | Enable pulse; each pulse advances sclk by a half period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1/2 transmit, 3/4 receive |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| miso0 | input | 1 | Serial data in, line 0 |
| miso1 | input | 1 | Serial data in, line 1 (two-line mode) |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi0 | output | 1 | Serial data out, line 0 |
| mosi1 | output | 1 | Serial data out, line 1 (two-line mode) |
| irq | output | 1 | Interrupt request |

## Verification
A bus model acting as the peripheral records every mosi bit and returns fixed 64-bit patterns. It also measures the time from each trailing edge to the next leading edge, so any gap shows up as an item with a length in clock cycles. The same 16-bit word is sent with and without byte reversal, which separates the reversal from plain shifting. The 24-bit case catches a swap that ignores the word length. Byte-gap runs with both polarities and two suspend values check the gap length and the edges that bound it. A burst with a large suspend value that is then disabled shows that the field has no effect without a burst. A two-line run with distinct patterns on each line shows whether the lines are crossed or share a register.

// File: rtl/spi_ro_pkg.sv
package spi_ro_pkg;

  localparam int unsigned CFG_W = 12;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_TX0  = 3'd1;
  localparam logic [2:0] ADR_TX1  = 3'd2;
  localparam logic [2:0] ADR_RX0  = 3'd3;
  localparam logic [2:0] ADR_RX1  = 3'd4;

  localparam int unsigned BIT_GO   = 0;
  localparam int unsigned BIT_FLAG = 16;

  typedef struct packed {
    logic       ie;
    logic       twobit;
    logic [3:0] susp;
    logic       burst;
    logic [1:0] omode;
    logic [1:0] wlen;
    logic       pol;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_st_e;

  function automatic cfg_t cfg_from_word(input logic [31:0] w);
    cfg_t c;
    c.pol    = w[1];
    c.wlen   = w[4:3];
    c.omode  = w[6:5];
    c.burst  = w[7];
    c.susp   = w[11:8];
    c.twobit = w[12];
    c.ie     = w[13];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_word(input cfg_t c, input logic busy,
                                            input logic flag);
    logic [31:0] w;
    w         = '0;
    w[BIT_GO] = busy;
    w[1]      = c.pol;
    w[4:3]    = c.wlen;
    w[6:5]    = c.omode;
    w[7]      = c.burst;
    w[11:8]   = c.susp;
    w[12]     = c.twobit;
    w[13]     = c.ie;
    w[BIT_FLAG] = flag;
    return w;
  endfunction

endpackage

// File: rtl/spi_ro_byteswap.sv
module spi_ro_byteswap #(
  parameter int unsigned DW  = 32,
  localparam int unsigned NB  = DW / 8,
  localparam int unsigned NBW = $clog2(NB + 1)
) (
  input  logic [DW-1:0]  din,
  input  logic [NBW-1:0] nbytes,
  input  logic           swap_en,
  output logic [DW-1:0]  dout
);

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    always_comb begin
      dout[gi*8 +: 8] = 8'h00;
      if (gi < int'(nbytes)) begin
        if (!swap_en) begin
          dout[gi*8 +: 8] = din[gi*8 +: 8];
        end else begin
          for (int j = 0; j < NB; j++) begin
            if (j == int'(nbytes) - 1 - gi) dout[gi*8 +: 8] = din[j*8 +: 8];
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_ro_regs.sv
module spi_ro_regs
  import spi_ro_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          eng_done,
  input  logic          rx_we0,
  input  logic          rx_we1,
  input  logic [DW-1:0] rx_d0,
  input  logic [DW-1:0] rx_d1,
  output cfg_t          cfg,
  output logic [DW-1:0] tx0,
  output logic [DW-1:0] tx1,
  output logic          start,
  output logic          busy,
  output logic          flag,
  output logic          irq
);

  cfg_t          cfg_q, cfg_d;
  logic          busy_q, busy_d;
  logic          flag_q, flag_d;
  logic          start_q, start_d;
  logic [DW-1:0] tx0_q, tx0_d, tx1_q, tx1_d;
  logic [DW-1:0] rx0_q, rx0_d, rx1_q, rx1_d;
  logic          wr_ok;

  assign wr_ok = wr && !busy_q;

  always_comb begin
    cfg_d   = cfg_q;
    busy_d  = busy_q;
    flag_d  = flag_q;
    start_d = 1'b0;
    tx0_d   = tx0_q;
    tx1_d   = tx1_q;
    rx0_d   = rx0_q;
    rx1_d   = rx1_q;
    if (wr_ok) begin
      unique case (addr)
        ADR_CTRL: begin
          cfg_d = cfg_from_word(wdata);
          if (wdata[BIT_FLAG]) flag_d = 1'b0;
          if (wdata[BIT_GO]) begin
            start_d = 1'b1;
            busy_d  = 1'b1;
          end
        end
        ADR_TX0: tx0_d = wdata[DW-1:0];
        ADR_TX1: tx1_d = wdata[DW-1:0];
        default: ;
      endcase
    end
    if (rx_we0) rx0_d = rx_d0;
    if (rx_we1) rx1_d = rx_d1;
    if (eng_done) begin
      busy_d = 1'b0;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
      start_q <= 1'b0;
      tx0_q   <= '0;
      tx1_q   <= '0;
      rx0_q   <= '0;
      rx1_q   <= '0;
    end else begin
      cfg_q   <= cfg_d;
      busy_q  <= busy_d;
      flag_q  <= flag_d;
      start_q <= start_d;
      tx0_q   <= tx0_d;
      tx1_q   <= tx1_d;
      rx0_q   <= rx0_d;
      rx1_q   <= rx1_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADR_CTRL: rdata = ctrl_word(cfg_q, busy_q, flag_q);
      ADR_TX0:  rdata = 32'(tx0_q);
      ADR_TX1:  rdata = 32'(tx1_q);
      ADR_RX0:  rdata = 32'(rx0_q);
      ADR_RX1:  rdata = 32'(rx1_q);
      default:  rdata = '0;
    endcase
  end

  assign cfg   = cfg_q;
  assign tx0   = tx0_q;
  assign tx1   = tx1_q;
  assign start = start_q;
  assign busy  = busy_q;
  assign flag  = flag_q;
  assign irq   = flag_q && cfg_q.ie;

endmodule

// File: rtl/spi_ro_engine.sv
module spi_ro_engine
  import spi_ro_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned SPW = 4,
  localparam int unsigned NB  = DW / 8,
  localparam int unsigned NBW = $clog2(NB + 1),
  localparam int unsigned BCW = $clog2(DW + 1),
  localparam int unsigned GCW = SPW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  cfg_t          cfg,
  input  logic [DW-1:0] tx0,
  input  logic [DW-1:0] tx1,
  input  logic          miso0,
  input  logic          miso1,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi0,
  output logic          mosi1,
  output logic          rx_we0,
  output logic          rx_we1,
  output logic [DW-1:0] rx_d0,
  output logic [DW-1:0] rx_d1,
  output logic          done
);

  eng_st_e       st_q, st_d;
  logic          ph_q, ph_d;
  logic          act_q, act_d;
  logic          csn_q, csn_d;
  logic          idx_q, idx_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [GCW-1:0] gcnt_q, gcnt_d;
  logic [DW-1:0] sh0_q, sh0_d, sh1_q, sh1_d;
  logic [DW-1:0] rs0_q, rs0_d, rs1_q, rs1_d;

  logic [NBW-1:0] nbytes;
  logic [BCW-1:0] last_bit;
  logic [BCW-1:0] align;
  logic [GCW-1:0] gap_last;
  logic           swap_en, bgap_en, two_tr, last, fin;
  logic [DW-1:0]  src0, tsw0, tsw1, rsw0, rsw1;

  assign nbytes   = (cfg.wlen == 2'd0) ? NBW'(NB) : NBW'(cfg.wlen);
  assign last_bit = BCW'(int'(nbytes) * 8 - 1);
  assign align    = BCW'(int'(DW) - int'(nbytes) * 8);
  assign gap_last = GCW'(2 * int'(cfg.susp) + 2);
  assign swap_en  = (cfg.omode == 2'b01) || (cfg.omode == 2'b10);
  assign bgap_en  = (cfg.omode == 2'b01) || (cfg.omode == 2'b11);
  assign two_tr   = cfg.burst && !cfg.twobit;
  assign src0     = (st_q == ST_IDLE) ? tx0 : tx1;

  spi_ro_byteswap #(.DW(DW)) u_tsw0 (.din(src0),  .nbytes(nbytes), .swap_en(swap_en), .dout(tsw0));
  spi_ro_byteswap #(.DW(DW)) u_tsw1 (.din(tx1),   .nbytes(nbytes), .swap_en(swap_en), .dout(tsw1));
  spi_ro_byteswap #(.DW(DW)) u_rsw0 (.din(rs0_q), .nbytes(nbytes), .swap_en(swap_en), .dout(rsw0));
  spi_ro_byteswap #(.DW(DW)) u_rsw1 (.din(rs1_q), .nbytes(nbytes), .swap_en(swap_en), .dout(rsw1));

  assign last   = (bcnt_q == last_bit);
  assign fin    = (st_q == ST_SHIFT) && ph_q && tick && last;
  assign rx_we0 = fin && !idx_q;
  assign rx_we1 = fin && (idx_q || cfg.twobit);
  assign rx_d0  = rsw0;
  assign rx_d1  = cfg.twobit ? rsw1 : rsw0;
  assign done   = fin && !(two_tr && !idx_q);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    act_d  = act_q;
    csn_d  = csn_q;
    idx_d  = idx_q;
    bcnt_d = bcnt_q;
    gcnt_d = gcnt_q;
    sh0_d  = sh0_q;
    sh1_d  = sh1_q;
    rs0_d  = rs0_q;
    rs1_d  = rs1_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_SHIFT;
          ph_d   = 1'b0;
          act_d  = 1'b0;
          csn_d  = 1'b0;
          idx_d  = 1'b0;
          bcnt_d = '0;
          sh0_d  = tsw0 << align;
          sh1_d  = tsw1 << align;
          rs0_d  = '0;
          rs1_d  = '0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!ph_q) begin
            act_d = 1'b1;
            ph_d  = 1'b1;
            rs0_d = {rs0_q[DW-2:0], miso0};
            rs1_d = {rs1_q[DW-2:0], miso1};
          end else begin
            act_d  = 1'b0;
            ph_d   = 1'b0;
            bcnt_d = bcnt_q + 1'b1;
            sh0_d  = sh0_q << 1;
            sh1_d  = sh1_q << 1;
            if (last) begin
              if (two_tr && !idx_q) begin
                idx_d  = 1'b1;
                bcnt_d = '0;
                sh0_d  = tsw0 << align;
                rs0_d  = '0;
                st_d   = ST_GAP;
                gcnt_d = '0;
              end else begin
                st_d  = ST_IDLE;
                csn_d = 1'b1;
              end
            end else if (bgap_en && (bcnt_q[2:0] == 3'b111)) begin
              st_d   = ST_GAP;
              gcnt_d = '0;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gcnt_q == gap_last) st_d = ST_SHIFT;
          else gcnt_d = gcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      act_q  <= 1'b0;
      csn_q  <= 1'b1;
      idx_q  <= 1'b0;
      bcnt_q <= '0;
      gcnt_q <= '0;
      sh0_q  <= '0;
      sh1_q  <= '0;
      rs0_q  <= '0;
      rs1_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      act_q  <= act_d;
      csn_q  <= csn_d;
      idx_q  <= idx_d;
      bcnt_q <= bcnt_d;
      gcnt_q <= gcnt_d;
      sh0_q  <= sh0_d;
      sh1_q  <= sh1_d;
      rs0_q  <= rs0_d;
      rs1_q  <= rs1_d;
    end
  end

  assign sclk  = cfg.pol ^ act_q;
  assign cs_n  = csn_q;
  assign mosi0 = sh0_q[DW-1];
  assign mosi1 = sh1_q[DW-1];

endmodule

// File: rtl/spi_reorder_master.sv
module spi_reorder_master
  import spi_ro_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned SPW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_tick,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        miso0,
  input  logic        miso1,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi0,
  output logic        mosi1,
  output logic        irq
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  cfg_t          cfg;
  logic          cfg_pol;
  logic [DW-1:0] tx0, tx1, rx_d0, rx_d1;
  logic          start, busy, flag, done, rx_we0, rx_we1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign cfg_pol   = cfg.pol;

  spi_ro_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .eng_done(done),
    .rx_we0(rx_we0), .rx_we1(rx_we1), .rx_d0(rx_d0), .rx_d1(rx_d1),
    .cfg(cfg), .tx0(tx0), .tx1(tx1), .start(start), .busy(busy),
    .flag(flag), .irq(irq)
  );

  spi_ro_engine #(.DW(DW), .SPW(SPW)) u_eng (
    .clk(clk), .rst_n(rst_int_n), .tick(sclk_tick), .start(start),
    .cfg(cfg), .tx0(tx0), .tx1(tx1), .miso0(miso0), .miso1(miso1),
    .sclk(sclk), .cs_n(cs_n), .mosi0(mosi0), .mosi1(mosi1),
    .rx_we0(rx_we0), .rx_we1(rx_we1), .rx_d0(rx_d0), .rx_d1(rx_d1),
    .done(done)
  );

endmodule

// File: rtl/spi_reorder_master_chk.sv
module spi_reorder_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk_tick,
  input logic        sclk,
  input logic        cs_n,
  input logic        irq,
  input logic        busy,
  input logic        flag,
  input logic        pol,
  input logic [11:0] cfg_word
);

  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n) else $error("cs_n low outside a transfer"); // R11

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == pol)) else $error("sclk off idle level"); // R3

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_tick && !cs_n) |=> $stable(sclk)) else $error("sclk moved without tick"); // R3

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flag) else $error("flag not set at end"); // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag) else $error("irq without flag"); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_word)) else $error("config changed while busy"); // R12

endmodule

bind spi_reorder_master spi_reorder_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .sclk(sclk),
  .cs_n(cs_n), .irq(irq), .busy(busy), .flag(flag), .pol(cfg_pol),
  .cfg_word(cfg)
);

// File: tb/sim_spi_reorder_master.sv
`timescale 1ns/1ps
module sim_spi_reorder_master;

  logic        clk = 1'b0;
  logic        rst_n, sclk_tick, reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        miso0, miso1, sclk, cs_n, mosi0, mosi1, irq;

  always #4 clk = ~clk;

  spi_reorder_master u0 (
    .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .miso0(miso0), .miso1(miso1), .sclk(sclk), .cs_n(cs_n),
    .mosi0(mosi0), .mosi1(mosi1), .irq(irq)
  );

  typedef struct { string tag; logic [63:0] v; } item_t;
  item_t       exp_q[$];
  logic [63:0] obs_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done_all = 0;
  logic [31:0] model_rx1 = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      item_t it;
      logic [63:0] ob;
      wait (exp_q.size() > 0 && obs_q.size() > 0);
      it = exp_q.pop_front();
      ob = obs_q.pop_front();
      check(it.tag, ob, it.v);
    end
  end

  // peripheral-side bus model
  logic [63:0] spat0, spat1, stx0, stx1, cap0, cap1;
  int          ecnt;
  time         t_trail;
  logic        pol_b = 1'b0;
  assign miso0 = stx0[63];
  assign miso1 = stx1[63];

  initial begin stx0 = '0; stx1 = '0; cap0 = '0; cap1 = '0; ecnt = 0; t_trail = 0; end

  always @(negedge cs_n) begin
    stx0 = spat0; stx1 = spat1; cap0 = '0; cap1 = '0; ecnt = 0;
  end

  always @(sclk) begin
    if (cs_n == 1'b0) begin
      if (sclk != pol_b) begin
        if (ecnt > 0 && ($time - t_trail) != 16) obs_q.push_back(64'(($time - t_trail) / 8));
        cap0 = {cap0[62:0], mosi0};
        cap1 = {cap1[62:0], mosi1};
        ecnt++;
      end else begin
        stx0 = stx0 << 1;
        stx1 = stx1 << 1;
        t_trail = $time;
      end
    end
  end

  initial begin
    sclk_tick = 1'b0;
    forever begin @(negedge clk); sclk_tick = ~sclk_tick; end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    c = 32'h1;
    while (c[0]) rd(3'd0, c);
  endtask

  function automatic logic [63:0] bsw(input logic [63:0] v, input int nb);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < nb; i++) r[8*i +: 8] = v[8*(nb-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mkctrl(input logic [1:0] wl, input logic [1:0] om,
      input logic pol, input logic burst, input logic twob, input logic ie, input logic [3:0] sp);
    return (32'(twob) << 12) | (32'(ie) << 13) | (32'(sp) << 8) | (32'(burst) << 7) |
           (32'(om) << 5) | (32'(wl) << 3) | (32'(pol) << 1);
  endfunction

  task automatic push_exp(input string tag, input logic [63:0] v);
    item_t it;
    it.tag = tag; it.v = v;
    exp_q.push_back(it);
  endtask

  task automatic xfer(input string rq, input logic [1:0] wl, input logic [1:0] om,
      input logic pol, input logic burst, input logic twob, input logic ie,
      input logic [3:0] sp, input logic [31:0] t0, input logic [31:0] t1,
      input logic [63:0] p0, input logic [63:0] p1, input bit disturb);
    int nb, L, ntr, gapc;
    bit reo, bg;
    logic [63:0] mask, m, w, raw, m1;
    logic [31:0] c, r;
    nb   = (wl == 0) ? 4 : int'(wl);
    L    = nb * 8;
    reo  = (om == 2'b01) || (om == 2'b10);
    bg   = (om == 2'b01) || (om == 2'b11);
    ntr  = (burst && !twob) ? 2 : 1;
    gapc = 4 * (int'(sp) + 2);
    mask = (64'd1 << L) - 1;
    for (int t = 0; t < ntr; t++) begin
      if (t == 1) push_exp({rq, " R7 burst gap"}, 64'(gapc));
      if (bg) for (int k = 0; k < nb - 1; k++) push_exp({rq, " R6 byte gap"}, 64'(gapc));
    end
    push_exp({rq, " R2 bit count"}, 64'(ntr * L));
    m = '0;
    for (int t = 0; t < ntr; t++) begin
      w = (t == 0) ? 64'(t0) & mask : 64'(t1) & mask;
      if (reo) w = bsw(w, nb);
      m = (m << L) | w;
    end
    push_exp({rq, " mosi0"}, m);
    if (twob) begin
      m1 = 64'(t1) & mask;
      if (reo) m1 = bsw(m1, nb);
      push_exp({rq, " R9 mosi1"}, m1);
    end
    raw = (p0 >> (64 - L)) & mask;
    push_exp({rq, " rx0"}, reo ? bsw(raw, nb) : raw);
    if (twob) begin
      raw = (p1 >> (64 - L)) & mask;
      model_rx1 = 32'(reo ? bsw(raw, nb) : raw);
    end else if (ntr == 2) begin
      raw = (p0 >> (64 - 2 * L)) & mask;
      model_rx1 = 32'(reo ? bsw(raw, nb) : raw);
    end
    push_exp({rq, " rx1"}, 64'(model_rx1));
    spat0 = p0; spat1 = p1; pol_b = pol;
    wr(3'd1, t0);
    wr(3'd2, t1);
    c = mkctrl(wl, om, pol, burst, twob, ie, sp);
    wr(3'd0, c | 32'h1);
    rd(3'd0, r);
    check({rq, " R11 busy reads 1"}, 64'(r[0]), 64'd1);
    if (disturb) begin
      wr(3'd0, 32'h0000_0000);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd2, 32'h0);
    end
    wait_idle();
    obs_q.push_back(64'(ecnt));
    obs_q.push_back(cap0);
    if (twob) obs_q.push_back(cap1 & mask);
    rd(3'd3, r); obs_q.push_back(64'(r));
    rd(3'd4, r); obs_q.push_back(64'(r));
    repeat (3) @(posedge clk);
    check({rq, " scoreboard drained"}, 64'(exp_q.size() + obs_q.size()), 64'd0);
    exp_q.delete();
    obs_q.delete();
    if (disturb) begin
      rd(3'd0, r);
      check({rq, " R12 ctrl unchanged"}, 64'(r), 64'(c | 32'h0001_0000));
      rd(3'd1, r);
      check({rq, " R12 tx0 unchanged"}, 64'(r), 64'(t0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_all) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    spat0 = '0; spat1 = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 cs_n", 64'(cs_n), 64'd1);
    check("R1 sclk", 64'(sclk), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    rd(3'd0, r); check("R1 ctrl", 64'(r), 64'd0);
    rd(3'd3, r); check("R1 rx0", 64'(r), 64'd0);

    xfer("T1 8b R2",        2'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,
         32'h0000_00A5, 32'h0, 64'h3C11_2233_4455_6677, 64'h0, 0);
    xfer("T2 16b swap R5",  2'd2, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,
         32'h0000_1234, 32'h0, 64'hBEEF_0102_0304_0506, 64'h0, 0);
    xfer("T3 16b plain R4", 2'd2, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,
         32'h0000_1234, 32'h0, 64'hBEEF_0102_0304_0506, 64'h0, 0);
    check("R3 sclk idles at polarity 1", 64'(sclk), 64'd1);
    xfer("T4 24b swap R5",  2'd3, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,
         32'h00AB_CDEF, 32'h0, 64'hC0FF_EE12_3456_789A, 64'h0, 0);
    check("R3 sclk idles at polarity 0", 64'(sclk), 64'd0);
    xfer("T5 32b swap+gap R6", 2'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1,
         32'h1122_3344, 32'h0, 64'h8765_4321_0FED_CBA9, 64'h0, 0);
    xfer("T6 32b gap pol1 R6", 2'd0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,
         32'hA1B2_C3D4, 32'h0, 64'h5A5A_C3C3_1234_5678, 64'h0, 0);
    xfer("T7 burst R7",     2'd2, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5,
         32'h0000_CAFE, 32'h0000_F00D, 64'h1357_9BDF_2468_ACE0, 64'h0, 0);
    xfer("T8 no burst R8",  2'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd15,
         32'hDEAD_BEEF, 32'h0, 64'h0F1E_2D3C_4B5A_6978, 64'h0, 0);
    xfer("T9 two-line R9",  2'd1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,
         32'h0000_0096, 32'h0000_0069, 64'hE700_0000_0000_0000, 64'h1800_0000_0000_0000, 0);
    xfer("T10 busy writes R12", 2'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3,
         32'h0102_0304, 32'h0, 64'hFACE_B00C_0000_1111, 64'h0, 1);
    // R10 flag and irq
    check("R10 irq with ie and flag", 64'(irq), 64'd1);
    wr(3'd0, mkctrl(2'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3));
    rd(3'd0, r); check("R10 write 0 keeps flag", 64'(r[16]), 64'd1);
    wr(3'd0, mkctrl(2'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3) | 32'h0001_0000);
    rd(3'd0, r); check("R10 write 1 clears flag", 64'(r[16]), 64'd0);
    check("R10 irq low after clear", 64'(irq), 64'd0);
    xfer("T11 ie off R10", 2'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,
         32'h0000_0033, 32'h0, 64'h7700_0000_0000_0000, 64'h0, 0);
    rd(3'd0, r); check("R10 flag set ie off", 64'(r[16]), 64'd1);
    check("R10 irq masked", 64'(irq), 64'd0);
    check("R11 cs_n high after end", 64'(cs_n), 64'd1);

    done_all = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule